// File: doc/BRIEF.md
# Power Button and Rail Supervisor

This block sits in an always-on controller and looks after the main power rail and the system reset of the machine it serves. Two raw button inputs, power and reset, are brought into the clock domain and debounced on a millisecond tick. A one-bit power-control register, written through a simple strobe, drives the DC/DC enable output. If the power button is held long enough, the block clears that register itself and switches the rail off, whatever the host is doing.

An external sampler supplies two 8-bit rail voltage codes at 1/32 V per LSB, one for the 3.3 V rail and one for the 5.0 V rail. A strobe marks each new sample. Each code is checked against a fixed window. The active-low system reset is held low until a sample finds both rails inside their windows, and it is also driven low while the debounced reset button is pressed. Two one-cycle events feed an interrupt register kept outside this block: a power-button change event for interrupt bit 6 and a voltage-alarm event for interrupt bit 7.

Top module: `pwr_supervisor`

## Requirements
- R1: A cycle with `ctrl_wr` high loads `ctrl_wdata[0]` into the enable bit, which shows on `ctrl_rdata[0]` and `dcdc_en` from the next cycle (1 = on, 0 = off). `ctrl_rdata[7:1]` always reads as zero. The bit resets to `EN_AT_RESET`, which defaults to 1.
- R2: When the debounced power button has been pressed for `HOLD_MS` ticks, the enable bit and `dcdc_en` are cleared, overriding a host write in the same cycle. This happens once per hold, and the hold count clears when the button is released.
- R3: While the debounced reset button is pressed, `sys_rst_n` is driven low from the next cycle. The reset button never appears in `btn_status`.
- R4: `btn_status[0]` is the debounced power button (1 = pressed, with a high raw input meaning pressed). `btn_status[7:1]` reads as zero.
- R5: Each raw button input passes through two synchronising flops. A new level is accepted only after it has stayed different from the accepted level for `DEBOUNCE_MS` consecutive ticks, so shorter pulses have no effect.
- R6: The 3.3 V rail is in window for codes 95 to 116 inclusive. A sample that takes it out of window raises `evt_volt_alarm` for one cycle, in the cycle after `sample_valid`.
- R7: The 5.0 V rail is in window for codes 144 to 176 inclusive, and it raises the alarm under the same rule as R6.
- R8: The alarm fires only when a rail enters the out-of-window state. Further samples that stay out of window, or that move to the other side of the window, raise no alarm.
- R9: Every edge of the debounced power button, press or release, gives a one-cycle pulse on `evt_btn_change`.
- R10: `sys_rst_n` is low from reset until a sample finds both rails in window. It rises two cycles after that `sample_valid`, and it returns low two cycles after any sample that finds a rail out of window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| pwr_btn_raw | input | 1 | Raw power button, high = pressed |
| rst_btn_raw | input | 1 | Raw reset button, high = pressed |
| ctrl_wr | input | 1 | Write strobe for the power-control register |
| ctrl_wdata | input | 8 | Write data; bit 0 is the enable |
| ctrl_rdata | output | 8 | Power-control register readback |
| btn_status | output | 8 | Button status; bit 0 is the power button |
| sample_valid | input | 1 | New rail codes are present |
| rail33_code | input | 8 | 3.3 V rail code, 1/32 V per LSB |
| rail50_code | input | 8 | 5.0 V rail code, 1/32 V per LSB |
| dcdc_en | output | 1 | DC/DC enable |
| sys_rst_n | output | 1 | Active-low system reset |
| evt_btn_change | output | 1 | One-cycle power button change event |
| evt_volt_alarm | output | 1 | One-cycle voltage alarm event |

## Verification
The bench builds the block with `DEBOUNCE_MS` = 4 and `HOLD_MS` = 40, and with the tick pulsing every fourth clock. This makes both the debounce acceptance and the forced shutdown take a few hundred cycles rather than millions. The window limits keep their default values, so every boundary code (94, 95, 116, 117, 143, 144, 176, 177) can be driven exactly. The short hold time also lets the bench press, release and press again in one run, to show that the hold count clears on release.

// File: rtl/pwr_sup_pkg.sv
package pwr_sup_pkg;
  typedef logic [7:0] code_t;

  function automatic logic code_in_window(code_t c, code_t lo, code_t hi);
    return (c >= lo) && (c <= hi);
  endfunction
endpackage

// File: rtl/btn_debounce.sv
module btn_debounce #(
  parameter int DB_TICKS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic raw,
  output logic stable
);
  localparam int CW = $clog2(DB_TICKS + 1);

  logic          s1_q, s2_q;
  logic          stb_q, stb_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= raw;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    stb_d = stb_q;
    if (s2_q != stb_q) begin
      if (tick) begin
        if (cnt_q == CW'(DB_TICKS - 1)) begin
          stb_d = s2_q;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      stb_q <= stb_d;
      cnt_q <= cnt_d;
    end
  end

  assign stable = stb_q;

  // R5: the accepted level changes only on a tick
  a_r5_change_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stb_q) |-> $past(tick));
endmodule

// File: rtl/rail_window.sv
module rail_window
  import pwr_sup_pkg::*;
#(
  parameter code_t LO = 8'd95,
  parameter code_t HI = 8'd116
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sample_valid,
  input  code_t code,
  output logic  in_win,
  output logic  alarm
);
  logic out_q, out_d;
  logic alarm_q, alarm_d;

  assign in_win = code_in_window(code, LO, HI);

  always_comb begin
    out_d   = out_q;
    alarm_d = 1'b0;
    if (sample_valid) begin
      out_d   = !in_win;
      alarm_d = !in_win && !out_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= 1'b0;
      alarm_q <= 1'b0;
    end else begin
      out_q   <= out_d;
      alarm_q <= alarm_d;
    end
  end

  assign alarm = alarm_q;

  // R6, R7: an alarm always follows a sample
  a_r6_alarm_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_q |-> $past(sample_valid));
  // R8: no alarm while the rail was already out of window
  a_r8_entry_only: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_q |-> !$past(out_q));
endmodule

// File: rtl/pwr_supervisor.sv
module pwr_supervisor
  import pwr_sup_pkg::*;
#(
  parameter int    DEBOUNCE_MS = 20,
  parameter int    HOLD_MS     = 3000,
  parameter logic  EN_AT_RESET = 1'b1,
  parameter code_t R33_LO      = 8'd95,
  parameter code_t R33_HI      = 8'd116,
  parameter code_t R50_LO      = 8'd144,
  parameter code_t R50_HI      = 8'd176
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       pwr_btn_raw,
  input  logic       rst_btn_raw,
  input  logic       ctrl_wr,
  input  logic [7:0] ctrl_wdata,
  output logic [7:0] ctrl_rdata,
  output logic [7:0] btn_status,
  input  logic       sample_valid,
  input  logic [7:0] rail33_code,
  input  logic [7:0] rail50_code,
  output logic       dcdc_en,
  output logic       sys_rst_n,
  output logic       evt_btn_change,
  output logic       evt_volt_alarm
);
  localparam int    NRAIL = 2;
  localparam int    HW    = $clog2(HOLD_MS + 1);
  localparam code_t LO_TAB [NRAIL] = '{R33_LO, R50_LO};
  localparam code_t HI_TAB [NRAIL] = '{R33_HI, R50_HI};

  // button conditioning
  logic [1:0] raw_vec, deb_vec;
  assign raw_vec = {rst_btn_raw, pwr_btn_raw};

  for (genvar b = 0; b < 2; b++) begin : g_btn
    btn_debounce #(.DB_TICKS(DEBOUNCE_MS)) i_deb (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (ms_tick),
      .raw    (raw_vec[b]),
      .stable (deb_vec[b])
    );
  end

  logic pwr_deb, rst_deb;
  assign pwr_deb = deb_vec[0];
  assign rst_deb = deb_vec[1];

  // rail windows
  code_t      codes [NRAIL];
  logic [NRAIL-1:0] in_win, alarm_vec;
  assign codes[0] = rail33_code;
  assign codes[1] = rail50_code;

  for (genvar r = 0; r < NRAIL; r++) begin : g_rail
    rail_window #(.LO(LO_TAB[r]), .HI(HI_TAB[r])) i_win (
      .clk          (clk),
      .rst_n        (rst_n),
      .sample_valid (sample_valid),
      .code         (codes[r]),
      .in_win       (in_win[r]),
      .alarm        (alarm_vec[r])
    );
  end

  // state
  logic          en_q, en_d;
  logic [HW-1:0] hold_q, hold_d;
  logic          force_off;
  logic          pwr_prev_q;
  logic          rails_ok_q, rails_ok_d;
  logic          srst_n_q, srst_n_d;

  assign force_off = pwr_deb && ms_tick && (hold_q == HW'(HOLD_MS - 1));

  always_comb begin
    hold_d = hold_q;
    if (!pwr_deb) begin
      hold_d = '0;
    end else if (ms_tick && (hold_q != HW'(HOLD_MS))) begin
      hold_d = hold_q + 1'b1;
    end

    en_d = en_q;
    if (force_off) begin
      en_d = 1'b0;
    end else if (ctrl_wr) begin
      en_d = ctrl_wdata[0];
    end

    rails_ok_d = rails_ok_q;
    if (sample_valid) begin
      rails_ok_d = &in_win;
    end

    srst_n_d = rails_ok_q && !rst_deb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= EN_AT_RESET;
      hold_q     <= '0;
      pwr_prev_q <= 1'b0;
      rails_ok_q <= 1'b0;
      srst_n_q   <= 1'b0;
    end else begin
      en_q       <= en_d;
      hold_q     <= hold_d;
      pwr_prev_q <= pwr_deb;
      rails_ok_q <= rails_ok_d;
      srst_n_q   <= srst_n_d;
    end
  end

  assign ctrl_rdata     = {7'd0, en_q};
  assign btn_status     = {7'd0, pwr_deb};
  assign dcdc_en        = en_q;
  assign sys_rst_n      = srst_n_q;
  assign evt_btn_change = pwr_deb ^ pwr_prev_q;
  assign evt_volt_alarm = |alarm_vec;

  // R1: a host write without a forced shutdown sets the enable
  a_r1_write_drives_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !force_off) |=> (dcdc_en == $past(ctrl_wdata[0])));
  // R2: a completed hold switches the rail off
  a_r2_hold_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    force_off |=> !dcdc_en);
  // R3: a pressed reset button holds the system in reset
  a_r3_reset_follows_button: assert property (@(posedge clk) disable iff (!rst_n)
    rst_deb |=> !sys_rst_n);
  // R10: a sample with a rail out of window re-asserts reset
  a_r10_rail_out_resets: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && !(&in_win)) |=> ##1 !sys_rst_n);
endmodule

// File: tb/test_pwr_supervisor.sv
module test_pwr_supervisor;
  localparam int DB   = 4;
  localparam int HOLD = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ms_tick = 1'b0;
  logic       pwr_btn_raw = 1'b0;
  logic       rst_btn_raw = 1'b0;
  logic       ctrl_wr = 1'b0;
  logic [7:0] ctrl_wdata = 8'd0;
  logic [7:0] ctrl_rdata;
  logic [7:0] btn_status;
  logic       sample_valid = 1'b0;
  logic [7:0] rail33_code = 8'd0;
  logic [7:0] rail50_code = 8'd0;
  logic       dcdc_en, sys_rst_n, evt_btn_change, evt_volt_alarm;

  int checks = 0;
  int fails  = 0;
  int btn_evts = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwr_supervisor #(.DEBOUNCE_MS(DB), .HOLD_MS(HOLD)) i_pwr_supervisor (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
    .pwr_btn_raw(pwr_btn_raw), .rst_btn_raw(rst_btn_raw),
    .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
    .btn_status(btn_status), .sample_valid(sample_valid),
    .rail33_code(rail33_code), .rail50_code(rail50_code),
    .dcdc_en(dcdc_en), .sys_rst_n(sys_rst_n),
    .evt_btn_change(evt_btn_change), .evt_volt_alarm(evt_volt_alarm)
  );

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      ms_tick = 1'b1;
      @(negedge clk);
      ms_tick = 1'b0;
    end
  end

  always @(posedge clk) if (rst_n && evt_btn_change) btn_evts <= btn_evts + 1;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_ticks(int n);
    repeat (n * 4) @(negedge clk);
  endtask

  task automatic host_write(logic [7:0] d);
    @(negedge clk);
    ctrl_wr = 1'b1; ctrl_wdata = d;
    @(negedge clk);
    ctrl_wr = 1'b0;
  endtask

  // returns at the negedge where the alarm event is visible
  task automatic sample(logic [7:0] a, logic [7:0] b, int exp_alarm, string req);
    @(negedge clk);
    rail33_code = a; rail50_code = b; sample_valid = 1'b1;
    @(negedge clk);
    sample_valid = 1'b0;
    check(req, evt_volt_alarm, exp_alarm);
  endtask

  task automatic t_reset_state;
    check("R1 enable after reset", dcdc_en, 1);
    check("R1 readback after reset", ctrl_rdata, 8'h01);
    check("R4 status after reset", btn_status, 0);
    check("R10 reset held before samples", sys_rst_n, 0);
  endtask

  task automatic t_rails;
    sample(8'd105, 8'd160, 0, "R6 nominal no alarm");
    @(negedge clk);
    check("R10 reset released", sys_rst_n, 1);
    sample(8'd117, 8'd160, 1, "R6 above 116 alarms");
    @(negedge clk);
    check("R10 reset re-asserted", sys_rst_n, 0);
    sample(8'd117, 8'd160, 0, "R8 no repeat while out");
    sample(8'd116, 8'd160, 0, "R6 116 in window");
    @(negedge clk);
    check("R10 reset released at 116", sys_rst_n, 1);
    sample(8'd94, 8'd160, 1, "R6 below 95 alarms");
    sample(8'd95, 8'd144, 0, "R7 95 and 144 in window");
    sample(8'd95, 8'd143, 1, "R7 below 144 alarms");
    sample(8'd95, 8'd177, 0, "R8 crossing sides no alarm");
    sample(8'd105, 8'd176, 0, "R7 176 in window");
    sample(8'd105, 8'd177, 1, "R7 above 176 alarms");
    sample(8'd105, 8'd160, 0, "R6 back to nominal");
    @(negedge clk);
    check("R10 reset released again", sys_rst_n, 1);
  endtask

  task automatic t_glitch;
    int e0 = btn_evts;
    pwr_btn_raw = 1'b1;
    wait_ticks(DB - 2);
    pwr_btn_raw = 1'b0;
    wait_ticks(DB + 3);
    check("R5 short pulse ignored status", btn_status, 0);
    check("R5 short pulse no event", btn_evts - e0, 0);
  endtask

  task automatic t_press_release;
    int e0 = btn_evts;
    pwr_btn_raw = 1'b1;
    wait_ticks(DB + 3);
    check("R4 pressed status", btn_status, 8'h01);
    check("R9 press event", btn_evts - e0, 1);
    pwr_btn_raw = 1'b0;
    wait_ticks(DB + 3);
    check("R4 released status", btn_status, 0);
    check("R9 release event", btn_evts - e0, 2);
    check("R2 short press keeps power", dcdc_en, 1);
  endtask

  task automatic t_hold;
    pwr_btn_raw = 1'b1;
    wait_ticks(DB + 3 + HOLD - 10);
    check("R2 on before hold time", dcdc_en, 1);
    wait_ticks(18);
    check("R2 forced off after hold", dcdc_en, 0);
    check("R2 register cleared", ctrl_rdata, 0);
    host_write(8'h01);
    wait_ticks(10);
    check("R2 single shutdown per hold", dcdc_en, 1);
    pwr_btn_raw = 1'b0;
    wait_ticks(DB + 3);
    // two partial holds separated by a release
    pwr_btn_raw = 1'b1;
    wait_ticks(DB + 25);
    pwr_btn_raw = 1'b0;
    wait_ticks(DB + 3);
    pwr_btn_raw = 1'b1;
    wait_ticks(DB + 25);
    check("R2 hold count clears on release", dcdc_en, 1);
    pwr_btn_raw = 1'b0;
    wait_ticks(DB + 3);
  endtask

  task automatic t_reset_button;
    check("R3 reset released before press", sys_rst_n, 1);
    rst_btn_raw = 1'b1;
    wait_ticks(DB + 3);
    check("R3 reset asserted by button", sys_rst_n, 0);
    check("R3 reset button not in status", btn_status, 0);
    rst_btn_raw = 1'b0;
    wait_ticks(DB + 3);
    check("R3 reset released after button", sys_rst_n, 1);
  endtask

  task automatic t_host_write;
    host_write(8'hFE);
    check("R1 write zero turns off", dcdc_en, 0);
    check("R1 reserved bits read zero", ctrl_rdata, 0);
    host_write(8'h01);
    check("R1 write one turns on", dcdc_en, 1);
    check("R1 readback one", ctrl_rdata, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_rails();
    t_glitch();
    t_press_release();
    t_hold();
    t_reset_button();
    t_host_write();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule